// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the stack pointer of an 8-bit processor whose stack grows from high addresses toward low ones. The processor reads and writes the pointer through two byte-wide bus registers, a low half and a high half. The instruction sequencer drives four mutually exclusive strobes:

- a single-byte push,
- a single-byte pop,
- a two-byte return-address push, used for a call or an interrupt entry,
- a two-byte return-address pop, used for a return from a subroutine or from an interrupt.

For each strobe the block supplies the data-memory address, or two addresses, at which the access takes place in that same cycle. It moves the pointer at the next clock edge.

A single-byte push stores at the current pointer and then decrements it. A single-byte pop increments the pointer and then reads. A return-address push places the low byte at SP and the high byte at SP-1, then lowers the pointer by two. A return-address pop reads the high byte at SP+1 and the low byte at SP+2, then raises the pointer by two.

Parts with a small data space can drop the high half with a parameter. The pointer then becomes 8 bits wide. Software must load the pointer, normally with the top of RAM, before it issues any call or enables interrupts. The reset value is a parameter that defaults to the top of RAM.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the low and high read ports show RESET_SP[7:0] and RESET_SP[15:8], op_err_o is 0, and both address outputs are 0.
- R2: With push_i as the only strobe and no register write, acc_lo_addr_o equals the current pointer and acc_hi_addr_o is 0 in that cycle, and the pointer is one lower after the edge.
- R3: With pop_i as the only strobe and no register write, acc_lo_addr_o equals the pointer plus 1 and acc_hi_addr_o is 0, and the pointer is one higher after the edge.
- R4: With call_i as the only strobe and no register write, acc_lo_addr_o (low byte of the return address) equals the pointer, acc_hi_addr_o (high byte) equals the pointer minus 1, and the pointer is two lower after the edge.
- R5: With ret_i as the only strobe and no register write, acc_hi_addr_o equals the pointer plus 1, acc_lo_addr_o equals the pointer plus 2, and the pointer is two higher after the edge.
- R6: When two or more strobes are high in the same cycle, op_err_o is 1 in that cycle, both address outputs are 0, and the pointer does not change.
- R7: A bus write loads the byte on reg_wdata_i into the selected half at the next edge. In a cycle with any bus write, the strobes do not move the pointer, although the addresses and op_err_o still follow the strobes.
- R8: reg_lo_o and reg_hi_o always show the current low and high halves of the pointer.
- R9: Pointer arithmetic and the address outputs wrap modulo 2^16, or modulo 2^8 when the high half is absent.
- R10: With HAS_HIGH = 0, reg_hi_o reads 0, a write to the high half leaves the pointer unchanged, and the pointer and addresses wrap within 8 bits.
- R11: With no strobe and no write, op_err_o is 0, both addresses are 0, and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_lo_i | input | 1 | Bus write to the low half |
| reg_wr_hi_i | input | 1 | Bus write to the high half |
| reg_wdata_i | input | 8 | Bus write data |
| push_i | input | 1 | Single-byte push strobe |
| pop_i | input | 1 | Single-byte pop strobe |
| call_i | input | 1 | Return-address push strobe (call or interrupt) |
| ret_i | input | 1 | Return-address pop strobe (return or interrupt return) |
| reg_lo_o | output | 8 | Low half of the pointer |
| reg_hi_o | output | 8 | High half of the pointer, 0 when absent |
| acc_lo_addr_o | output | 16 | Address of a single-byte access, or of the return address low byte |
| acc_hi_addr_o | output | 16 | Address of the return address high byte, otherwise 0 |
| op_err_o | output | 1 | More than one strobe is high in this cycle |

## Verification
The checker verifies on every cycle the properties that hold edge to edge:

- the single-step move for each lone strobe,
- the adjacency of the two return-address addresses,
- that a strobe clash freezes the pointer,
- that a bus write wins,
- that the high half is absent in the narrow variant.

The bench's scenarios are what show the absolute values: the reset contents, the wrap at 0x0000 and 0xFFFF (and at 0x00/0xFF in the 8-bit variant), and the long mixed runs compared cycle by cycle with a behavioural model across both widths. A write to the high half that vanishes in the narrow variant can also be seen only through those runs.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH1,
    OP_POP1,
    OP_PUSH2,
    OP_POP2,
    OP_CLASH
  } stk_op_e;
endpackage

// File: rtl/stack_op_decode.sv
module stack_op_decode
  import stack_ptr_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    call_i,
  input  logic    ret_i,
  output stk_op_e op_o
);
  logic [3:0] strb;
  assign strb = {ret_i, call_i, pop_i, push_i};

  always_comb begin
    case (strb)
      4'b0000: op_o = OP_IDLE;
      4'b0001: op_o = OP_PUSH1;
      4'b0010: op_o = OP_POP1;
      4'b0100: op_o = OP_PUSH2;
      4'b1000: op_o = OP_POP2;
      default: op_o = OP_CLASH;
    endcase
  end
endmodule

// File: rtl/stack_ptr_arith.sv
module stack_ptr_arith
  import stack_ptr_pkg::*;
#(
  parameter int SP_W = 16
) (
  input  stk_op_e           op_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic [SP_W-1:0]   sp_next_o,
  output logic [ADDR_W-1:0] addr_lo_o,
  output logic [ADDR_W-1:0] addr_hi_o,
  output logic              step_o
);
  logic [SP_W-1:0] sp_m1, sp_m2, sp_p1, sp_p2;

  assign sp_m1 = sp_i - SP_W'(1);
  assign sp_m2 = sp_i - SP_W'(2);
  assign sp_p1 = sp_i + SP_W'(1);
  assign sp_p2 = sp_i + SP_W'(2);

  // zero-extend a pointer-width value to a bus address
  function automatic logic [ADDR_W-1:0] widen(input logic [SP_W-1:0] v);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[SP_W-1:0] = v;
    return r;
  endfunction

  always_comb begin
    sp_next_o = sp_i;
    addr_lo_o = '0;
    addr_hi_o = '0;
    step_o    = 1'b0;
    case (op_i)
      OP_PUSH1: begin
        addr_lo_o = widen(sp_i);
        sp_next_o = sp_m1;
        step_o    = 1'b1;
      end
      OP_POP1: begin
        addr_lo_o = widen(sp_p1);
        sp_next_o = sp_p1;
        step_o    = 1'b1;
      end
      OP_PUSH2: begin
        addr_lo_o = widen(sp_i);
        addr_hi_o = widen(sp_m1);
        sp_next_o = sp_m2;
        step_o    = 1'b1;
      end
      OP_POP2: begin
        addr_hi_o = widen(sp_p1);
        addr_lo_o = widen(sp_p2);
        sp_next_o = sp_p2;
        step_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_ptr_regs.sv
module stack_ptr_regs
  import stack_ptr_pkg::*;
#(
  parameter int          SP_W     = 16,
  parameter bit          HAS_HIGH = 1'b1,
  parameter logic [15:0] RESET_SP = 16'h08FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic [SP_W-1:0]   sp_next_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              upd;

  // any bus write suppresses the strobe update in that cycle
  assign upd = step_i && !wr_lo_i && !wr_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= RESET_SP[BYTE_W-1:0];
    else if (wr_lo_i) lo_q <= wdata_i;
    else if (upd)     lo_q <= sp_next_i[BYTE_W-1:0];
  end

  assign lo_o = lo_q;

  if (HAS_HIGH) begin : g_high
    logic [BYTE_W-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hi_q <= RESET_SP[15:8];
      else if (wr_hi_i) hi_q <= wdata_i;
      else if (upd)     hi_q <= sp_next_i[SP_W-1:BYTE_W];
    end
    assign hi_o = hi_q;
    assign sp_o = {hi_q, lo_q};
  end else begin : g_low_only
    assign hi_o = '0;
    assign sp_o = lo_q;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter bit          HAS_HIGH = 1'b1,
  parameter logic [15:0] RESET_SP = 16'h08FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_lo_i,
  input  logic              reg_wr_hi_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  output logic [BYTE_W-1:0] reg_lo_o,
  output logic [BYTE_W-1:0] reg_hi_o,
  output logic [ADDR_W-1:0] acc_lo_addr_o,
  output logic [ADDR_W-1:0] acc_hi_addr_o,
  output logic              op_err_o
);
  localparam int SP_W = HAS_HIGH ? 2 * BYTE_W : BYTE_W;

  stk_op_e         op;
  logic [SP_W-1:0] sp_q, sp_next;
  logic            step;

  stack_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op)
  );

  stack_ptr_arith #(.SP_W(SP_W)) u_arith (
    .op_i      (op),
    .sp_i      (sp_q),
    .sp_next_o (sp_next),
    .addr_lo_o (acc_lo_addr_o),
    .addr_hi_o (acc_hi_addr_o),
    .step_o    (step)
  );

  stack_ptr_regs #(.SP_W(SP_W), .HAS_HIGH(HAS_HIGH), .RESET_SP(RESET_SP)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (reg_wr_lo_i),
    .wr_hi_i   (reg_wr_hi_i),
    .wdata_i   (reg_wdata_i),
    .step_i    (step),
    .sp_next_i (sp_next),
    .sp_o      (sp_q),
    .lo_o      (reg_lo_o),
    .hi_o      (reg_hi_o)
  );

  assign op_err_o = (op == OP_CLASH);
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter bit HAS_HIGH = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_lo_i,
  input logic        reg_wr_hi_i,
  input logic [7:0]  reg_wdata_i,
  input logic        push_i,
  input logic        pop_i,
  input logic        call_i,
  input logic        ret_i,
  input logic [7:0]  reg_lo_o,
  input logic [7:0]  reg_hi_o,
  input logic [15:0] acc_lo_addr_o,
  input logic [15:0] acc_hi_addr_o,
  input logic        op_err_o
);
  localparam logic [15:0] MASK = HAS_HIGH ? 16'hFFFF : 16'h00FF;

  logic [15:0] ptr;
  logic [3:0]  strb;
  logic        no_wr;

  assign ptr   = {reg_hi_o, reg_lo_o};
  assign strb  = {ret_i, call_i, pop_i, push_i};
  assign no_wr = !reg_wr_lo_i && !reg_wr_hi_i;

  AST_PUSH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0001) |-> (acc_lo_addr_o == ptr && acc_hi_addr_o == 16'h0)); // R2
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0001 && no_wr) |=> (ptr == (($past(ptr) - 16'd1) & MASK))); // R2
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0010 && no_wr) |=> (ptr == (($past(ptr) + 16'd1) & MASK))); // R3
  AST_CALL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0100) |-> (acc_lo_addr_o == ptr &&
                           acc_hi_addr_o == ((acc_lo_addr_o - 16'd1) & MASK))); // R4
  AST_CALL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0100 && no_wr) |=> (ptr == (($past(ptr) - 16'd2) & MASK))); // R4
  AST_RET_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b1000) |-> (acc_hi_addr_o == ((ptr + 16'd1) & MASK) &&
                           acc_lo_addr_o == ((acc_hi_addr_o + 16'd1) & MASK))); // R5
  AST_RET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b1000 && no_wr) |=> (ptr == (($past(ptr) + 16'd2) & MASK))); // R5
  AST_CLASH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(strb) > 1) |-> (op_err_o && acc_lo_addr_o == 16'h0 && acc_hi_addr_o == 16'h0)); // R6
  AST_CLASH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(strb) > 1 && no_wr) |=> $stable(ptr)); // R6
  AST_WR_LO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_lo_i |=> (reg_lo_o == $past(reg_wdata_i))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0000 && no_wr) |=> $stable(ptr)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb == 4'b0000) |-> (!op_err_o && acc_lo_addr_o == 16'h0 && acc_hi_addr_o == 16'h0)); // R11
  AST_HI_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_HIGH |-> (reg_hi_o == 8'h0 && acc_lo_addr_o[15:8] == 8'h0)); // R10
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.HAS_HIGH(HAS_HIGH)) u_chk (.*);

// File: tb/stack_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wdata = 8'h0;
  logic        push = 1'b0, pop = 1'b0, call = 1'b0, ret = 1'b0;

  logic [7:0]  b_lo, b_hi, s_lo, s_hi;
  logic [15:0] b_alo, b_ahi, s_alo, s_ahi;
  logic        b_err, s_err;

  int compared = 0;
  int mismatched = 0;
  int sp_b, sp_s;

  always #2.5 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_lo_i(wr_lo), .reg_wr_hi_i(wr_hi),
    .reg_wdata_i(wdata), .push_i(push), .pop_i(pop), .call_i(call), .ret_i(ret),
    .reg_lo_o(b_lo), .reg_hi_o(b_hi), .acc_lo_addr_o(b_alo), .acc_hi_addr_o(b_ahi),
    .op_err_o(b_err));

  stack_ptr_unit #(.HAS_HIGH(1'b0), .RESET_SP(16'h00DF)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_lo_i(wr_lo), .reg_wr_hi_i(wr_hi),
    .reg_wdata_i(wdata), .push_i(push), .pop_i(pop), .call_i(call), .ret_i(ret),
    .reg_lo_o(s_lo), .reg_hi_o(s_hi), .acc_lo_addr_o(s_alo), .acc_hi_addr_o(s_ahi),
    .op_err_o(s_err));

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected outputs of one unit for the current strobes
  task automatic expect_outs(input int sp, input int mask, input bit pu, po, ca, re,
                             output int elo, output int ehi, output int eerr);
    int n = int'(pu) + int'(po) + int'(ca) + int'(re);
    elo = 0; ehi = 0; eerr = (n > 1) ? 1 : 0;
    if (n == 1) begin
      if (pu) elo = sp;
      if (po) elo = (sp + 1) & mask;
      if (ca) begin elo = sp; ehi = (sp - 1) & mask; end
      if (re) begin ehi = (sp + 1) & mask; elo = (sp + 2) & mask; end
    end
  endtask

  function automatic int next_sp(input int sp, input int mask, input bit hh,
                                 input bit pu, po, ca, re, wl, wh, input int wd);
    int n = int'(pu) + int'(po) + int'(ca) + int'(re);
    int lo, hi;
    if (wl || wh) begin
      lo = wl ? wd : (sp & 255);
      hi = (wh && hh) ? wd : ((sp >> 8) & 255);
      return ((hi << 8) | lo) & mask;
    end
    if (n != 1) return sp;
    if (pu) return (sp - 1) & mask;
    if (po) return (sp + 1) & mask;
    if (ca) return (sp - 2) & mask;
    return (sp + 2) & mask;
  endfunction

  task automatic compare_all(input string tag);
    int elo, ehi, eerr;
    expect_outs(sp_b, 16'hFFFF, push, pop, call, ret, elo, ehi, eerr);
    check(tag, "wide lo addr", int'(b_alo), elo);
    check(tag, "wide hi addr", int'(b_ahi), ehi);
    check(tag, "wide err", int'(b_err), eerr);
    check("R8", "wide reg lo", int'(b_lo), sp_b & 255);
    check("R8", "wide reg hi", int'(b_hi), (sp_b >> 8) & 255);
    expect_outs(sp_s, 16'h00FF, push, pop, call, ret, elo, ehi, eerr);
    check("R10", "narrow lo addr", int'(s_alo), elo);
    check("R10", "narrow hi addr", int'(s_ahi), ehi);
    check("R10", "narrow err", int'(s_err), eerr);
    check("R10", "narrow reg lo", int'(s_lo), sp_s & 255);
    check("R10", "narrow reg hi", int'(s_hi), 0);
  endtask

  task automatic step(input bit pu, po, ca, re, wl, wh, input logic [7:0] wd, input string tag);
    @(negedge clk);
    push = pu; pop = po; call = ca; ret = re;
    wr_lo = wl; wr_hi = wh; wdata = wd;
    #1;
    compare_all(tag);
    @(posedge clk);
    sp_b = next_sp(sp_b, 16'hFFFF, 1'b1, pu, po, ca, re, wl, wh, int'(wd));
    sp_s = next_sp(sp_s, 16'h00FF, 1'b0, pu, po, ca, re, wl, wh, int'(wd));
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    step(0, 0, 0, 0, 0, 1, hi, tag);
    step(0, 0, 0, 0, 1, 0, lo, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    sp_b = 16'h08FF;
    sp_s = 16'h00DF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset contents
    check("R1", "reset reg lo", int'(b_lo), 8'hFF);
    check("R1", "reset reg hi", int'(b_hi), 8'h08);
    check("R1", "reset err", int'(b_err), 0);
    check("R1", "reset addr", int'(b_alo), 0);
    check("R1", "reset narrow lo", int'(s_lo), 8'hDF);
    step(0, 0, 0, 0, 0, 0, 8'h00, "R11");
    step(1, 0, 0, 0, 0, 0, 8'h00, "R2");
    step(1, 0, 0, 0, 0, 0, 8'h00, "R2");
    step(0, 1, 0, 0, 0, 0, 8'h00, "R3");
    step(0, 0, 1, 0, 0, 0, 8'h00, "R4");
    step(0, 0, 1, 0, 0, 0, 8'h00, "R4");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R5");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R5");
    step(1, 1, 0, 0, 0, 0, 8'h00, "R6");
    step(0, 0, 1, 1, 0, 0, 8'h00, "R6");
    step(1, 1, 1, 1, 0, 0, 8'h00, "R6");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R11");
    step(1, 0, 0, 0, 1, 0, 8'h40, "R7");
    step(0, 0, 1, 0, 0, 1, 8'h12, "R7");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R7");
    // R9: wrap at the bottom and the top
    load(8'h00, 8'h00, "R9");
    step(1, 0, 0, 0, 0, 0, 8'h00, "R9");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R9");
    load(8'h00, 8'h01, "R9");
    step(0, 0, 1, 0, 0, 0, 8'h00, "R9");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R9");
    load(8'hFF, 8'hFF, "R9");
    step(0, 1, 0, 0, 0, 0, 8'h00, "R9");
    load(8'hFF, 8'hFE, "R9");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R9");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R9");
    // R10: high write ignored by the narrow unit
    load(8'h05, 8'h80, "R10");
    step(0, 0, 1, 0, 0, 0, 8'h00, "R10");
    // mixed run against the model
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 15));
      bit pu = (r == 0 || r == 1 || r == 2 || r == 12);
      bit po = (r == 3 || r == 4 || r == 5 || r == 12);
      bit ca = (r == 6 || r == 7 || r == 13);
      bit re = (r == 8 || r == 9 || r == 13);
      bit wl = (r == 10);
      bit wh = (r == 11);
      step(pu, po, ca, re, wl, wh, 8'($urandom), "R9");
    end
    step(0, 0, 0, 0, 0, 0, 8'h00, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule